// File: doc/BRIEF.md
# Cache Tag Check-Bit Generator and Corrector

This block guards the entries of a secondary cache tag store. A tag entry is a 25-bit tag kept beside 7 check bits, 32 bits in all. When a tag is written, the block turns the tag into its 32-bit protected word. When a tag is read, it computes a 7-bit syndrome, sorts the word into clean, single-bit error or uncorrectable, and produces a repaired tag next to the raw one.

The kind of access decides which tag answers the request and whether software is interrupted. A processor access that follows a primary-cache miss takes the raw tag and traps on any error. A snoop from outside the processor is answered from the repaired tag, and it still traps so that software can rewrite the stored entry. A cache-maintenance operation uses the repaired tag to form write-back addresses and line state. The tag memory and the trap handler sit outside the block.

The code can locate any single flipped bit. It also flags every double error, and every error of three or four bits that stays inside one aligned nibble of the word. Both write and read results come out of registers, one cycle after the request.

Top module: `tag_ecc_unit`

## Requirements
- R1: One cycle after `wr_valid`, `wr_word_valid` is high and `wr_word` holds the protected word. Nibble k is bits 4k+3..4k. Bit 4k+i has syndrome column {k (3 bits, high), one-hot i (4 bits, low)}. Check bits sit at positions 0, 1, 2, 3, 4, 8 and 16. The tag bits fill the other positions in ascending order, tag bit 0 lowest. The XOR of the columns of all set bits of the word is zero.
- R2: Reset is synchronous and active high, and it clears every output. One cycle after `rd_valid`, `out_valid` is high and `out_kind` repeats `rd_kind`. When `out_valid` is low, no error flag and no trap is raised.
- R3: A read of an unaltered word raises no flag. `raw_tag` and `corrected_tag` both equal the stored tag.
- R4: If one tag position of the word is flipped, `single_err` is raised and `corrected_tag` equals the original tag.
- R5: If one check position is flipped, `single_err` is raised and both `raw_tag` and `corrected_tag` equal the original tag.
- R6: If any two bits are flipped, `multi_err` is raised and `single_err` stays low.
- R7: If three or four bits are flipped, all inside one nibble, `multi_err` is raised and `single_err` stays low.
- R8: `rd_kind` uses this encoding: 00 is a processor miss, 01 is external, 10 is a cache operation, and 11 behaves as a processor miss. A processor miss answers `resp_tag` with `raw_tag` and raises `trap` on any error.
- R9: An external access answers `resp_tag` with the repaired tag. It raises `trap` on any error, including one that has been corrected.
- R10: A cache operation answers `resp_tag` with the repaired tag and never raises `trap`.
- R11: `uncorrectable` is high exactly when `multi_err` is high on an external access or a cache operation. It then marks `resp_tag` as not to be trusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Encode request |
| wr_tag | input | 25 | Tag to protect |
| wr_word_valid | output | 1 | Protected word valid |
| wr_word | output | 32 | Tag plus check bits, ready for storage |
| rd_valid | input | 1 | Check request |
| rd_kind | input | 2 | Access kind (see R8) |
| rd_word | input | 32 | Word read from the tag store |
| out_valid | output | 1 | Check result valid |
| out_kind | output | 2 | Access kind of the result |
| single_err | output | 1 | One bit was found in error and located |
| multi_err | output | 1 | Uncorrectable pattern detected |
| trap | output | 1 | Software must be interrupted |
| uncorrectable | output | 1 | Response is built on an uncorrectable tag |
| raw_tag | output | 25 | Tag bits as read |
| corrected_tag | output | 25 | Tag after single-bit repair |
| resp_tag | output | 25 | Tag chosen for the access kind |

## Verification
Every result, on both paths, is due exactly one rising edge after the cycle in which its request is presented. Stimulus is applied on falling edges. Each request pushes its expected result into a queue in the same step, and a monitor compares the outputs on every later falling edge. This means a reading is taken half a cycle after the register that produces it has loaded. Results are popped in request order, so a missing or extra result is caught both as a count mismatch at the end and as a value mismatch along the way. For multi-bit errors the repaired tag is not defined, so it is left unchecked there; the flags, the raw tag and the processor-miss response are still checked.

// File: rtl/tag_ecc_pkg.sv
package tag_ecc_pkg;

  typedef enum logic [1:0] {
    ACC_MISS = 2'b00,
    ACC_EXT  = 2'b01,
    ACC_CMO  = 2'b10,
    ACC_RSVD = 2'b11
  } access_e;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'b00,
    CLS_SINGLE = 2'b01,
    CLS_MULTI  = 2'b10
  } ecc_class_e;

  // Check positions: all of nibble 0, plus bit 0 of every nibble whose
  // index is a power of two.
  function automatic bit is_check_pos(int pos);
    int nib;
    nib = pos / 4;
    if (pos < 4) return 1'b1;
    return (pos % 4 == 0) && ((nib & (nib - 1)) == 0);
  endfunction

  // Tag bit index carried at a data position.
  function automatic int data_index(int pos);
    int n;
    n = 0;
    for (int q = 0; q < pos; q++)
      if (!is_check_pos(q)) n++;
    return n;
  endfunction

endpackage

// File: rtl/tag_ecc_encoder.sv
module tag_ecc_encoder
  import tag_ecc_pkg::*;
#(
  parameter int NIB_BITS = 3,
  localparam int WORD_W = 4 << NIB_BITS,
  localparam int CHK_W  = NIB_BITS + 4,
  localparam int TAG_W  = WORD_W - CHK_W
) (
  input  logic [TAG_W-1:0]  tag,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0]   placed;
  logic [NIB_BITS-1:0] su;
  logic [3:0]          sv;

  for (genvar p = 0; p < WORD_W; p++) begin : g_place
    if (is_check_pos(p)) begin : g_chk
      assign placed[p] = 1'b0;
    end else begin : g_dat
      localparam int DI = data_index(p);
      assign placed[p] = tag[DI];
    end
  end

  // Syndrome of the data alone; the check bits cancel it.
  always_comb begin
    su = '0;
    sv = '0;
    for (int p = 0; p < WORD_W; p++) begin
      for (int b = 0; b < NIB_BITS; b++)
        if (((p >> (2 + b)) & 1) == 1) su[b] = su[b] ^ placed[p];
      sv[p[1:0]] = sv[p[1:0]] ^ placed[p];
    end
  end

  for (genvar p = 0; p < WORD_W; p++) begin : g_out
    if (p == 0) begin : g_c0
      assign word[p] = sv[0] ^ (^su);
    end else if (p < 4) begin : g_clo
      assign word[p] = sv[p];
    end else if (is_check_pos(p)) begin : g_chi
      localparam int B = $clog2(p / 4);
      assign word[p] = su[B];
    end else begin : g_dat
      assign word[p] = placed[p];
    end
  end

endmodule

// File: rtl/tag_ecc_decoder.sv
module tag_ecc_decoder
  import tag_ecc_pkg::*;
#(
  parameter int NIB_BITS = 3,
  localparam int WORD_W = 4 << NIB_BITS,
  localparam int CHK_W  = NIB_BITS + 4,
  localparam int TAG_W  = WORD_W - CHK_W,
  localparam int POS_W  = NIB_BITS + 2
) (
  input  logic [WORD_W-1:0] word,
  output ecc_class_e        cls,
  output logic [POS_W-1:0]  err_pos,
  output logic [TAG_W-1:0]  raw_tag
);

  logic [NIB_BITS-1:0] su;
  logic [3:0]          sv;
  logic [1:0]          vidx;

  always_comb begin
    su = '0;
    sv = '0;
    for (int p = 0; p < WORD_W; p++) begin
      for (int b = 0; b < NIB_BITS; b++)
        if (((p >> (2 + b)) & 1) == 1) su[b] = su[b] ^ word[p];
      sv[p[1:0]] = sv[p[1:0]] ^ word[p];
    end
  end

  always_comb begin
    vidx = '0;
    for (int i = 0; i < 4; i++)
      if (sv[i]) vidx = 2'(i);
  end

  assign err_pos = {su, vidx};

  // Every column has exactly one low bit set, so a single error always
  // leaves a one-hot low syndrome; anything else is uncorrectable.
  always_comb begin
    if (su == '0 && sv == '0)      cls = CLS_CLEAN;
    else if ($countones(sv) == 1)  cls = CLS_SINGLE;
    else                           cls = CLS_MULTI;
  end

  for (genvar p = 0; p < WORD_W; p++) begin : g_ext
    if (!is_check_pos(p)) begin : g_dat
      localparam int DI = data_index(p);
      assign raw_tag[DI] = word[p];
    end
  end

endmodule

// File: rtl/tag_ecc_corrector.sv
module tag_ecc_corrector
  import tag_ecc_pkg::*;
#(
  parameter int NIB_BITS = 3,
  localparam int WORD_W = 4 << NIB_BITS,
  localparam int CHK_W  = NIB_BITS + 4,
  localparam int TAG_W  = WORD_W - CHK_W,
  localparam int POS_W  = NIB_BITS + 2
) (
  input  logic [TAG_W-1:0] raw_tag,
  input  ecc_class_e       cls,
  input  logic [POS_W-1:0] err_pos,
  output logic [TAG_W-1:0] corr_tag
);

  logic [TAG_W-1:0] flip;

  // Only tag positions have a flip bit; a located check-bit error
  // leaves the tag untouched.
  for (genvar p = 0; p < WORD_W; p++) begin : g_flip
    if (!is_check_pos(p)) begin : g_dat
      localparam int DI = data_index(p);
      assign flip[DI] = (cls == CLS_SINGLE) && (err_pos == POS_W'(p));
    end
  end

  assign corr_tag = raw_tag ^ flip;

endmodule

// File: rtl/tag_ecc_unit.sv
module tag_ecc_unit
  import tag_ecc_pkg::*;
#(
  parameter int NIB_BITS = 3,
  localparam int WORD_W = 4 << NIB_BITS,
  localparam int CHK_W  = NIB_BITS + 4,
  localparam int TAG_W  = WORD_W - CHK_W,
  localparam int POS_W  = NIB_BITS + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic              wr_word_valid,
  output logic [WORD_W-1:0] wr_word,
  input  logic              rd_valid,
  input  logic [1:0]        rd_kind,
  input  logic [WORD_W-1:0] rd_word,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic              single_err,
  output logic              multi_err,
  output logic              trap,
  output logic              uncorrectable,
  output logic [TAG_W-1:0]  raw_tag,
  output logic [TAG_W-1:0]  corrected_tag,
  output logic [TAG_W-1:0]  resp_tag
);

  logic [WORD_W-1:0] enc_word;
  ecc_class_e        cls;
  logic [POS_W-1:0]  err_pos;
  logic [TAG_W-1:0]  dec_raw;
  logic [TAG_W-1:0]  dec_corr;
  logic              use_corr;
  logic              any_err;
  logic              may_trap;

  tag_ecc_encoder #(.NIB_BITS(NIB_BITS)) u_enc (
    .tag  (wr_tag),
    .word (enc_word)
  );

  tag_ecc_decoder #(.NIB_BITS(NIB_BITS)) u_dec (
    .word    (rd_word),
    .cls     (cls),
    .err_pos (err_pos),
    .raw_tag (dec_raw)
  );

  tag_ecc_corrector #(.NIB_BITS(NIB_BITS)) u_cor (
    .raw_tag  (dec_raw),
    .cls      (cls),
    .err_pos  (err_pos),
    .corr_tag (dec_corr)
  );

  assign use_corr = (rd_kind == ACC_EXT) || (rd_kind == ACC_CMO);
  assign may_trap = (rd_kind != ACC_CMO);
  assign any_err  = (cls != CLS_CLEAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_word_valid <= 1'b0;
      wr_word       <= '0;
    end else begin
      wr_word_valid <= wr_valid;
      if (wr_valid) wr_word <= enc_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_kind      <= 2'b00;
      single_err    <= 1'b0;
      multi_err     <= 1'b0;
      trap          <= 1'b0;
      uncorrectable <= 1'b0;
      raw_tag       <= '0;
      corrected_tag <= '0;
      resp_tag      <= '0;
    end else begin
      out_valid     <= rd_valid;
      single_err    <= rd_valid && (cls == CLS_SINGLE);
      multi_err     <= rd_valid && (cls == CLS_MULTI);
      trap          <= rd_valid && any_err && may_trap;
      uncorrectable <= rd_valid && (cls == CLS_MULTI) && use_corr;
      if (rd_valid) begin
        out_kind      <= rd_kind;
        raw_tag       <= dec_raw;
        corrected_tag <= dec_corr;
        resp_tag      <= use_corr ? dec_corr : dec_raw;
      end
    end
  end

endmodule

// File: rtl/tag_ecc_checker.sv
module tag_ecc_checker
  import tag_ecc_pkg::*;
#(
  parameter int NIB_BITS = 3,
  localparam int WORD_W = 4 << NIB_BITS,
  localparam int CHK_W  = NIB_BITS + 4,
  localparam int TAG_W  = WORD_W - CHK_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_word_valid,
  input logic             rd_valid,
  input logic [1:0]       rd_kind,
  input logic             out_valid,
  input logic [1:0]       out_kind,
  input logic             single_err,
  input logic             multi_err,
  input logic             trap,
  input logic             uncorrectable,
  input logic [TAG_W-1:0] raw_tag,
  input logic [TAG_W-1:0] corrected_tag,
  input logic [TAG_W-1:0] resp_tag
);

  p_wr_latency_r1: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> wr_word_valid);

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (out_valid && out_kind == $past(rd_kind)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!single_err && !multi_err && !trap && !uncorrectable));

  p_clean_same_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !single_err && !multi_err) |-> (corrected_tag == raw_tag && !trap));

  p_single_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
    single_err |-> ($countones(corrected_tag ^ raw_tag) <= 1));

  p_class_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({single_err, multi_err}));

  p_miss_raw_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == ACC_MISS || out_kind == ACC_RSVD))
      |-> (resp_tag == raw_tag && trap == (single_err || multi_err)));

  p_ext_trap_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == ACC_EXT)
      |-> (resp_tag == corrected_tag && trap == (single_err || multi_err)));

  p_cmo_notrap_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == ACC_CMO) |-> (!trap && resp_tag == corrected_tag));

  p_uncorr_r11: assert property (@(posedge clk) disable iff (rst)
    uncorrectable |-> (multi_err && (out_kind == ACC_EXT || out_kind == ACC_CMO)));

endmodule

bind tag_ecc_unit tag_ecc_checker #(.NIB_BITS(NIB_BITS)) u_tag_ecc_checker (
  .clk           (clk),
  .rst           (rst),
  .wr_valid      (wr_valid),
  .wr_word_valid (wr_word_valid),
  .rd_valid      (rd_valid),
  .rd_kind       (rd_kind),
  .out_valid     (out_valid),
  .out_kind      (out_kind),
  .single_err    (single_err),
  .multi_err     (multi_err),
  .trap          (trap),
  .uncorrectable (uncorrectable),
  .raw_tag       (raw_tag),
  .corrected_tag (corrected_tag),
  .resp_tag      (resp_tag)
);

// File: tb/test_tag_ecc_unit.sv
module test_tag_ecc_unit;

  localparam int TW = 25;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [TW-1:0] wr_tag = '0;
  logic          wr_word_valid;
  logic [WW-1:0] wr_word;
  logic          rd_valid = 1'b0;
  logic [1:0]    rd_kind = 2'b00;
  logic [WW-1:0] rd_word = '0;
  logic          out_valid;
  logic [1:0]    out_kind;
  logic          single_err, multi_err, trap, uncorrectable;
  logic [TW-1:0] raw_tag, corrected_tag, resp_tag;

  always #10 clk = ~clk;

  tag_ecc_unit i_tag_ecc_unit (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_word_valid(wr_word_valid), .wr_word(wr_word),
    .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_word(rd_word),
    .out_valid(out_valid), .out_kind(out_kind),
    .single_err(single_err), .multi_err(multi_err),
    .trap(trap), .uncorrectable(uncorrectable),
    .raw_tag(raw_tag), .corrected_tag(corrected_tag), .resp_tag(resp_tag)
  );

  typedef struct {
    logic [1:0]    kind;
    logic          se, me, tr, uc;
    logic [TW-1:0] raw, corr, resp;
    bit            corr_known, resp_known;
  } rd_exp_t;

  rd_exp_t       rd_q[$];
  string         rd_req_q[$];
  logic [WW-1:0] wr_q[$];

  int checks = 0;
  int errors = 0;
  int cpos[7] = '{0, 1, 2, 3, 4, 8, 16};

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model built from the R1 statement of the code.
  function automatic bit b_is_chk(int pos);
    foreach (cpos[i]) if (cpos[i] == pos) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [6:0] b_col(int pos);
    logic [3:0] oh;
    oh = 4'b0001 << (pos % 4);
    return {3'(pos / 4), oh};
  endfunction

  function automatic logic [6:0] b_syn(logic [WW-1:0] w);
    logic [6:0] s;
    s = '0;
    for (int p = 0; p < WW; p++) if (w[p]) s = s ^ b_col(p);
    return s;
  endfunction

  function automatic logic [WW-1:0] b_encode(logic [TW-1:0] t);
    logic [WW-1:0] w;
    int d;
    w = '0;
    d = 0;
    for (int p = 0; p < WW; p++)
      if (!b_is_chk(p)) begin w[p] = t[d]; d++; end
    for (int c = 0; c < 128; c++) begin
      for (int i = 0; i < 7; i++) w[cpos[i]] = c[i];
      if (b_syn(w) == 7'd0) return w;
    end
    return 'x;
  endfunction

  function automatic logic [TW-1:0] b_extract(logic [WW-1:0] w);
    logic [TW-1:0] t;
    int d;
    t = '0;
    d = 0;
    for (int p = 0; p < WW; p++)
      if (!b_is_chk(p)) begin t[d] = w[p]; d++; end
    return t;
  endfunction

  task automatic do_write(input logic [TW-1:0] t);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_tag   = t;
    wr_q.push_back(b_encode(t));
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] kind, input logic [TW-1:0] t,
                         input logic [WW-1:0] flips, input string base);
    rd_exp_t e;
    logic [WW-1:0] w;
    int n;
    bit use_corr;
    string req;
    w = b_encode(t) ^ flips;
    n = $countones(flips);
    use_corr = (kind == 2'b01) || (kind == 2'b10);
    e.kind = kind;
    e.se = (n == 1);
    e.me = (n >= 2);
    e.tr = (n > 0) && (kind != 2'b10);
    e.uc = (n >= 2) && use_corr;
    e.raw = b_extract(w);
    e.corr = t;
    e.corr_known = (n <= 1);
    e.resp = use_corr ? t : e.raw;
    e.resp_known = !use_corr || (n <= 1);
    case (kind)
      2'b01:   req = {base, " R9"};
      2'b10:   req = {base, " R10"};
      default: req = {base, " R8"};
    endcase
    if (e.uc) req = {req, " R11"};
    @(negedge clk);
    rd_valid = 1'b1;
    rd_kind  = kind;
    rd_word  = w;
    rd_q.push_back(e);
    rd_req_q.push_back(req);
  endtask

  // Monitor: results are due one rising edge after the request.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (wr_word_valid) begin
          if (wr_q.size() == 0) chk("R1", "unexpected write result", 1, 0);
          else chk("R1", "wr_word", 64'(wr_word), 64'(wr_q.pop_front()));
        end
        if (out_valid) begin
          if (rd_q.size() == 0) chk("R2", "unexpected read result", 1, 0);
          else begin
            rd_exp_t e;
            string r;
            e = rd_q.pop_front();
            r = rd_req_q.pop_front();
            chk({r, " R2"}, "out_kind", 64'(out_kind), 64'(e.kind));
            chk(r, "single_err", 64'(single_err), 64'(e.se));
            chk(r, "multi_err", 64'(multi_err), 64'(e.me));
            chk(r, "trap", 64'(trap), 64'(e.tr));
            chk({r, " R11"}, "uncorrectable", 64'(uncorrectable), 64'(e.uc));
            chk(r, "raw_tag", 64'(raw_tag), 64'(e.raw));
            if (e.corr_known) chk(r, "corrected_tag", 64'(corrected_tag), 64'(e.corr));
            if (e.resp_known) chk(r, "resp_tag", 64'(resp_tag), 64'(e.resp));
          end
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TW-1:0] tags[6];
    logic [TW-1:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    chk("R2", "reset out_valid", 64'(out_valid), 0);
    chk("R2", "reset wr_word_valid", 64'(wr_word_valid), 0);
    chk("R2", "reset trap", 64'(trap), 0);
    chk("R2", "reset wr_word", 64'(wr_word), 0);
    chk("R2", "reset resp_tag", 64'(resp_tag), 0);
    rst = 1'b0;

    // R1: encoding of several tag patterns
    do_write('0);
    do_write('1);
    for (int k = 0; k < TW; k++) do_write(TW'(1) << k);
    lfsr = 25'h1ABCDE5;
    for (int k = 0; k < 12; k++) begin
      lfsr = {lfsr[23:0], lfsr[24] ^ lfsr[21]};
      do_write(lfsr);
    end
    // back-to-back writes
    @(negedge clk);
    wr_valid = 1'b1; wr_tag = 25'h0F0F0F0; wr_q.push_back(b_encode(25'h0F0F0F0));
    @(negedge clk);
    wr_tag = 25'h1234567; wr_q.push_back(b_encode(25'h1234567));
    @(negedge clk);
    wr_valid = 1'b0;

    tags[0] = '0;
    tags[1] = '1;
    tags[2] = 25'h0A5A5A5;
    tags[3] = 25'h1555555;
    tags[4] = 25'h0C3F00E;
    tags[5] = 25'h1F00C31;

    foreach (tags[ti]) begin
      // R3: clean reads on every access kind
      for (int k = 0; k < 4; k++) do_read(2'(k), tags[ti], '0, "R3");
      // R4 and R5: each single flip
      for (int p = 0; p < WW; p++)
        do_read(2'((p + ti) % 4), tags[ti], WW'(1) << p, b_is_chk(p) ? "R5" : "R4");
      // R6: double flips
      for (int p = 0; p < WW; p++) begin
        int q;
        q = (p * 7 + 3 + ti) % WW;
        if (q == p) q = (p + 1) % WW;
        do_read(2'(p % 4), tags[ti], (WW'(1) << p) | (WW'(1) << q), "R6");
      end
      // R7: three and four flips inside one nibble
      for (int nb = 0; nb < 8; nb++) begin
        for (int skip = 0; skip < 4; skip++)
          do_read(2'((nb + skip) % 4), tags[ti],
                  (WW'(4'hF & ~(4'h1 << skip))) << (4 * nb), "R7");
        do_read(2'((nb + ti) % 4), tags[ti], WW'(4'hF) << (4 * nb), "R7");
      end
    end
    @(negedge clk);
    rd_valid = 1'b0;

    repeat (4) @(negedge clk);
    chk("R2", "pending read results", 64'(rd_q.size()), 0);
    chk("R1", "pending write results", 64'(wr_q.size()), 0);
    chk("R2", "idle trap", 64'(trap), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule